// File: doc/BRIEF.md
# SMBus Descriptor Transaction Formatter

This block accepts one command descriptor and turns it into an ordered sequence of byte-level bus operations for a downstream SMBus/I2C bit engine. The operations are start, write byte, read byte with ACK or NACK, and stop. The descriptor fields are:

- a 7-bit target address and a read/write bit;
- a byte that holds either a write length or a literal command byte;
- a read length;
- a control byte.

Write data is fetched from a local byte buffer. Received data is written back into the same buffer, starting at index 0.

When the transaction ends, the block reports a status byte, the count of write-phase bytes the target acknowledged and the count of data bytes received. It presents them for one cycle. On the next cycle it raises a completion pulse, which can optionally raise an interrupt pulse as well.

The control byte changes the framing. One flag turns the length field into a literal command byte. A block flag inserts or expects an SMBus byte-count byte. An I2C flag suppresses that count byte, so the raw length framing is used instead.

Top module: `smbus_desc_fmt`

## Requirements
- R1: The first address byte sent is {addr[6:0], b}. Here b is 0 when a write phase exists and the descriptor's read/write bit otherwise. The bit value 1 means read.
- R2: With the command flag (control bit 0, value 0x01) clear, write length 0 and read length 0, the block performs a quick command: start, address byte, stop, and nothing else.
- R3: With control bit 0 set, the length field is sent as one literal byte. With it clear, the field is the number of bytes sent from buffer index 0 upward. The transmitted count equals the write bytes the target acknowledged.
- R4: When a write phase and a nonzero read length are both present, the block issues a repeated start, then the address byte with bit 0 set to 1, before the reads.
- R5: Every read byte is answered with ACK except the last data byte, which gets NACK. Data bytes are stored at buffer index 0, 1, ... in arrival order. The received count equals the number of bytes stored.
- R6: A NAK on any address byte or write byte is followed directly by stop, with no further write or read. The status is then exactly 0x08.
- R7: Block framing applies when the block flag (0x04) is set and the I2C flag (0x20) is clear. A buffer write then sends a count byte equal to the write length minus 1 right after buffer byte 0. A read first receives a count byte, answers it with ACK and does not store it; that count sets the number of data bytes.
- R8: Under block framing, a received count that is 0, above MAX_BLK (32), or above the read length ends the transfer with stop. The status is then exactly 0x80 and the received count is 0.
- R9: With the I2C flag set, no count byte is inserted or expected. A read returns exactly read-length bytes.
- R10: The status bit 0x01 is set if and only if no error bit (0x08, 0x80) is set.
- R11: The status and counts are valid for exactly one cycle on wb_valid. done pulses on the next cycle, and irq pulses with done only when control bit 0x40 is set.
- R12: desc_ready is high only when the block is idle, so a descriptor offered during a transaction is not taken. An operation stays valid with stable contents until op_done.
- R13: After reset, desc_ready is 1 and op_valid, wb_valid, done and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor taken |
| desc_addr | input | 7 | Target address |
| desc_rw | input | 1 | Read/write bit (1 = read) |
| desc_wlc | input | LEN_W | Write length or command byte |
| desc_rlen | input | LEN_W | Read length |
| desc_ctrl | input | 8 | Control flags |
| op_valid | output | 1 | Bus operation pending |
| op_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| op_data | output | 8 | Byte to write |
| op_ack | output | 1 | Read response: 1 ACK, 0 NACK |
| op_done | input | 1 | Engine finished the operation |
| op_nak | input | 1 | Target NAKed the written byte |
| op_rdata | input | 8 | Byte read from target |
| buf_addr | output | BUF_AW | Buffer index |
| buf_rd_en | output | 1 | Buffer read (data one cycle later) |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write |
| buf_wdata | output | 8 | Buffer write data |
| wb_valid | output | 1 | Write-back fields valid |
| wb_status | output | 8 | Status byte |
| wb_rx_cnt | output | LEN_W | Received data bytes |
| wb_tx_cnt | output | LEN_W | Acknowledged write bytes |
| done | output | 1 | Completion pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest situations to reach are the error exits in the middle of a transfer:

- a NAK on the repeated-start address after the write phase has already been acknowledged;
- a block-read count byte that is out of range.

The bench's target model reacts to each operation from a per-case plan. The plan names which write-class operation is NAKed and which bytes, including the count byte, are returned. This lets any operation in the stream fail on demand. One case also holds a conflicting descriptor on the input throughout a transaction to show it is never taken.

// File: rtl/smbf_pkg.sv
`timescale 1ns/1ps
package smbf_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_kind_t;

  // control-byte flag positions
  localparam int CTL_CMD = 0;
  localparam int CTL_BLK = 2;
  localparam int CTL_I2C = 5;
  localparam int CTL_IRQ = 6;

  // status byte values
  localparam logic [7:0] ST_OK  = 8'h01;
  localparam logic [7:0] ST_NAK = 8'h08;
  localparam logic [7:0] ST_BIG = 8'h80;
endpackage

// File: rtl/smbf_wsrc.sv
`timescale 1ns/1ps
// Chooses the source of the next write-phase byte.
module smbf_wsrc #(
  parameter int LEN_W  = 8,
  parameter int BUF_AW = 6
) (
  input  logic              is_cmd,
  input  logic              ins_cnt,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [LEN_W-1:0]  idx,
  output logic              from_buf,
  output logic [7:0]        lit,
  output logic [BUF_AW-1:0] bidx,
  output logic              last
);
  localparam int CW = LEN_W + 1;
  logic [CW-1:0] total;

  assign total    = is_cmd ? CW'(1) : CW'(wlen) + CW'(ins_cnt);
  assign last     = (CW'(idx) + CW'(1)) == total;
  assign from_buf = !is_cmd && !(ins_cnt && idx == LEN_W'(1));
  assign lit      = is_cmd ? 8'(wlen) : 8'(wlen - LEN_W'(1));
  assign bidx     = BUF_AW'((ins_cnt && idx > LEN_W'(1)) ? idx - LEN_W'(1) : idx);
endmodule

// File: rtl/smbf_rdctl.sv
`timescale 1ns/1ps
// Read-phase response and block-count range check.
module smbf_rdctl #(
  parameter int LEN_W   = 8,
  parameter int MAX_BLK = 32
) (
  input  logic             blk_fmt,
  input  logic             got_len,
  input  logic [LEN_W-1:0] rx_cnt,
  input  logic [LEN_W-1:0] nread,
  input  logic [LEN_W-1:0] rlen,
  input  logic [7:0]       rdata,
  output logic             ack,
  output logic             last,
  output logic             len_bad
);
  assign last    = (rx_cnt + LEN_W'(1)) == nread;
  assign ack     = (blk_fmt && !got_len) ? 1'b1 : !last;
  assign len_bad = (rdata == 8'd0) || (int'(rdata) > MAX_BLK) || (LEN_W'(rdata) > rlen);
endmodule

// File: rtl/smbf_status.sv
`timescale 1ns/1ps
module smbf_status
  import smbf_pkg::*;
(
  input  logic       nak_err,
  input  logic       big_err,
  output logic [7:0] status
);
  assign status = (nak_err ? ST_NAK : 8'h00) |
                  (big_err ? ST_BIG : 8'h00) |
                  ((!nak_err && !big_err) ? ST_OK : 8'h00);
endmodule

// File: rtl/smbus_desc_fmt.sv
`timescale 1ns/1ps
module smbus_desc_fmt
  import smbf_pkg::*;
#(
  parameter int BUF_AW  = 6,
  parameter int MAX_BLK = 32,
  parameter int LEN_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [6:0]        desc_addr,
  input  logic              desc_rw,
  input  logic [LEN_W-1:0]  desc_wlc,
  input  logic [LEN_W-1:0]  desc_rlen,
  input  logic [7:0]        desc_ctrl,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic [7:0]        op_data,
  output logic              op_ack,
  input  logic              op_done,
  input  logic              op_nak,
  input  logic [7:0]        op_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [7:0]        buf_rdata,
  output logic              buf_wr_en,
  output logic [7:0]        buf_wdata,
  output logic              wb_valid,
  output logic [7:0]        wb_status,
  output logic [LEN_W-1:0]  wb_rx_cnt,
  output logic [LEN_W-1:0]  wb_tx_cnt,
  output logic              done,
  output logic              irq
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_WR, S_WF1, S_WF2, S_WSEND, S_RD, S_STOP, S_FIN
  } state_t;

  state_t           state;
  op_kind_t         kind_q;
  logic [6:0]       d_addr;
  logic             d_rw, f_cmd, f_blk, f_i2c, f_irq;
  logic [LEN_W-1:0] d_wlc, d_rlen, nread, tx_cnt, rx_cnt;
  logic             rd_pass, got_len, e_nak, e_big;
  logic             ctl_unused;

  logic             blk_fmt, has_wr, has_rd;
  logic             ws_from_buf, ws_last;
  logic [7:0]       ws_lit;
  logic [BUF_AW-1:0] ws_bidx;
  logic             rc_ack, rc_last, rc_bad;
  logic [7:0]       st_byte;

  assign ctl_unused = ^{desc_ctrl[7], desc_ctrl[4:3], desc_ctrl[1]};
  assign blk_fmt    = f_blk && !f_i2c;
  assign has_wr     = f_cmd || (d_wlc != '0);
  assign has_rd     = d_rlen != '0;
  assign desc_ready = (state == S_IDLE);
  assign op_kind    = kind_q;
  assign wb_rx_cnt  = rx_cnt;
  assign wb_tx_cnt  = tx_cnt;

  smbf_wsrc #(.LEN_W(LEN_W), .BUF_AW(BUF_AW)) u_wsrc (
    .is_cmd(f_cmd), .ins_cnt(blk_fmt), .wlen(d_wlc), .idx(tx_cnt),
    .from_buf(ws_from_buf), .lit(ws_lit), .bidx(ws_bidx), .last(ws_last)
  );

  smbf_rdctl #(.LEN_W(LEN_W), .MAX_BLK(MAX_BLK)) u_rdctl (
    .blk_fmt(blk_fmt), .got_len(got_len), .rx_cnt(rx_cnt), .nread(nread),
    .rlen(d_rlen), .rdata(op_rdata), .ack(rc_ack), .last(rc_last), .len_bad(rc_bad)
  );

  smbf_status u_status (.nak_err(e_nak), .big_err(e_big), .status(st_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      kind_q <= OP_START;
      op_valid <= 1'b0; op_data <= '0; op_ack <= 1'b0;
      buf_addr <= '0; buf_rd_en <= 1'b0; buf_wr_en <= 1'b0; buf_wdata <= '0;
      wb_valid <= 1'b0; wb_status <= '0; done <= 1'b0; irq <= 1'b0;
      d_addr <= '0; d_rw <= 1'b0; d_wlc <= '0; d_rlen <= '0;
      f_cmd <= 1'b0; f_blk <= 1'b0; f_i2c <= 1'b0; f_irq <= 1'b0;
      nread <= '0; tx_cnt <= '0; rx_cnt <= '0;
      rd_pass <= 1'b0; got_len <= 1'b0; e_nak <= 1'b0; e_big <= 1'b0;
    end else begin
      buf_rd_en <= 1'b0;
      buf_wr_en <= 1'b0;
      wb_valid  <= 1'b0;
      done      <= 1'b0;
      irq       <= 1'b0;
      case (state)
        S_IDLE: if (desc_valid) begin
          d_addr <= desc_addr; d_rw <= desc_rw;
          d_wlc <= desc_wlc; d_rlen <= desc_rlen;
          f_cmd <= desc_ctrl[CTL_CMD]; f_blk <= desc_ctrl[CTL_BLK];
          f_i2c <= desc_ctrl[CTL_I2C]; f_irq <= desc_ctrl[CTL_IRQ];
          tx_cnt <= '0; rx_cnt <= '0; rd_pass <= 1'b0; got_len <= 1'b0;
          e_nak <= 1'b0; e_big <= 1'b0;
          state <= S_START;
        end
        S_START: if (!op_valid) begin
          op_valid <= 1'b1; kind_q <= OP_START;
        end else if (op_done) begin
          op_valid <= 1'b0; state <= S_ADDR;
        end
        S_ADDR: if (!op_valid) begin
          op_valid <= 1'b1; kind_q <= OP_WRITE;
          op_data <= {d_addr, rd_pass ? 1'b1 : (has_wr ? 1'b0 : d_rw)};
        end else if (op_done) begin
          op_valid <= 1'b0;
          if (op_nak) begin
            e_nak <= 1'b1; state <= S_STOP;
          end else if (!rd_pass && has_wr) begin
            state <= S_WR;
          end else if (has_rd) begin
            nread <= d_rlen; state <= S_RD;
          end else begin
            state <= S_STOP;
          end
        end
        S_WR: if (ws_from_buf) begin
          buf_rd_en <= 1'b1; buf_addr <= ws_bidx; state <= S_WF1;
        end else begin
          op_valid <= 1'b1; kind_q <= OP_WRITE; op_data <= ws_lit; state <= S_WSEND;
        end
        S_WF1: state <= S_WF2;
        S_WF2: begin
          op_valid <= 1'b1; kind_q <= OP_WRITE; op_data <= buf_rdata; state <= S_WSEND;
        end
        S_WSEND: if (op_done) begin
          op_valid <= 1'b0;
          if (op_nak) begin
            e_nak <= 1'b1; state <= S_STOP;
          end else begin
            tx_cnt <= tx_cnt + LEN_W'(1);
            if (ws_last) begin
              rd_pass <= has_rd;
              state <= has_rd ? S_START : S_STOP;
            end else begin
              state <= S_WR;
            end
          end
        end
        S_RD: if (!op_valid) begin
          op_valid <= 1'b1; kind_q <= OP_READ; op_ack <= rc_ack;
        end else if (op_done) begin
          op_valid <= 1'b0;
          if (blk_fmt && !got_len) begin
            got_len <= 1'b1;
            if (rc_bad) begin
              e_big <= 1'b1; state <= S_STOP;
            end else begin
              nread <= LEN_W'(op_rdata);
            end
          end else begin
            buf_wr_en <= 1'b1; buf_addr <= rx_cnt[BUF_AW-1:0]; buf_wdata <= op_rdata;
            rx_cnt <= rx_cnt + LEN_W'(1);
            if (rc_last) state <= S_STOP;
          end
        end
        S_STOP: if (!op_valid) begin
          op_valid <= 1'b1; kind_q <= OP_STOP;
        end else if (op_done) begin
          op_valid <= 1'b0; wb_status <= st_byte; wb_valid <= 1'b1; state <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1; irq <= f_irq; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  wb_then_done_chk: assert property (@(posedge clk) disable iff (rst) wb_valid |=> done);
  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (rst) irq |-> done);
  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst) op_valid |-> !desc_ready);
  // R12
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_done) |=> (op_valid && $stable(op_kind) && $stable(op_data) && $stable(op_ack)));
  // R10
  ok_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_status[0]) |-> (wb_status[7:1] == 7'd0));
  // R10
  status_nonzero_chk: assert property (@(posedge clk) disable iff (rst) wb_valid |-> (wb_status != 8'h00));
  // R5
  rd_last_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_done && op_kind == OP_READ && !op_ack) |=> (buf_wr_en && !op_valid));
  // R5
  buf_port_chk: assert property (@(posedge clk) disable iff (rst) !(buf_wr_en && buf_rd_en));
endmodule

// File: tb/smbus_desc_fmt_test.sv
`timescale 1ns/1ps
module smbus_desc_fmt_test;
  logic clk = 1'b0;
  logic rst;
  logic desc_valid, desc_ready, desc_rw;
  logic [6:0] desc_addr;
  logic [7:0] desc_wlc, desc_rlen, desc_ctrl;
  logic op_valid, op_ack, op_done, op_nak;
  logic [1:0] op_kind;
  logic [7:0] op_data, op_rdata;
  logic [5:0] buf_addr;
  logic buf_rd_en, buf_wr_en;
  logic [7:0] buf_rdata, buf_wdata;
  logic wb_valid, done, irq;
  logic [7:0] wb_status, wb_rx_cnt, wb_tx_cnt;

  logic [7:0] mem [64];
  int nchk = 0;
  int nerr = 0;

  // expected operation stream and target responses
  int e_kind[$], e_val[$], e_nak[$], e_rd[$];
  int sb[$];
  int wd[$];
  int ex_buf[64];
  int ex_tx, ex_rx, ex_st, wi;
  bit abort_f;

  always #10 clk = ~clk;

  smbus_desc_fmt uut (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_rw(desc_rw), .desc_wlc(desc_wlc), .desc_rlen(desc_rlen),
    .desc_ctrl(desc_ctrl), .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
    .op_ack(op_ack), .op_done(op_done), .op_nak(op_nak), .op_rdata(op_rdata),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
    .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .wb_valid(wb_valid),
    .wb_status(wb_status), .wb_rx_cnt(wb_rx_cnt), .wb_tx_cnt(wb_tx_cnt),
    .done(done), .irq(irq)
  );

  always @(posedge clk) begin
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_op(input int k, input int v, input int n, input int r);
    e_kind.push_back(k); e_val.push_back(v); e_nak.push_back(n); e_rd.push_back(r);
  endtask

  task automatic push_w(input int b, input int nakw);
    bit nk;
    nk = (wi == nakw);
    wi++;
    push_op(1, b, nk, 0);
    if (nk) begin ex_st = 8'h08; abort_f = 1; end
  endtask

  // behavioural model of the expected transaction
  task automatic build(input int a, input int rw, input int wlc, input int rl, input int c, input int nakw);
    bit blkf, hw;
    int wl[$];
    int n, si, len;
    e_kind.delete(); e_val.delete(); e_nak.delete(); e_rd.delete();
    wi = 0; abort_f = 0; ex_tx = 0; ex_rx = 0; ex_st = 0;
    blkf = c[2] && !c[5];
    hw = c[0] || (wlc != 0);
    push_op(0, 0, 0, 0);
    push_w(a * 2 + (hw ? 0 : rw), nakw);
    if (!abort_f && hw) begin
      if (c[0]) wl.push_back(wlc);
      else for (int i = 0; i < wlc; i++) begin
        wl.push_back(wd[i]);
        if (blkf && i == 0) wl.push_back(wlc - 1);
      end
      foreach (wl[i]) if (!abort_f) begin
        push_w(wl[i], nakw);
        if (!abort_f) ex_tx++;
      end
      if (!abort_f && rl != 0) begin
        push_op(0, 0, 0, 0);
        push_w(a * 2 + 1, nakw);
      end
    end
    if (!abort_f && rl != 0) begin
      n = rl; si = 0;
      if (blkf) begin
        len = sb[0]; si = 1;
        push_op(2, 1, 0, len);
        if (len == 0 || len > 32 || len > rl) begin ex_st = 8'h80; abort_f = 1; end
        n = len;
      end
      if (!abort_f) for (int k = 0; k < n; k++) begin
        push_op(2, (k != n - 1), 0, sb[si + k]);
        ex_buf[k] = sb[si + k];
        ex_rx++;
      end
    end
    push_op(3, 0, 0, 0);
    if (ex_st == 0) ex_st = 1;
  endtask

  task automatic run_case(input string tag, input int a, input int rw, input int wlc,
                          input int rl, input int c, input int nakw, input bit junk);
    bit seen_wb, fin;
    int cyc, k, v, n, r;
    string st_tag;
    build(a, rw, wlc, rl, c, nakw);
    foreach (wd[i]) mem[i] = 8'(wd[i]);
    @(negedge clk);
    desc_addr = 7'(a); desc_rw = rw[0]; desc_wlc = 8'(wlc); desc_rlen = 8'(rl);
    desc_ctrl = 8'(c); desc_valid = 1'b1;
    @(negedge clk);
    chk(desc_ready == 1'b0, "R12", "ready while busy", desc_ready, 0);
    if (junk) begin
      desc_addr = 7'h7F; desc_rw = 1'b1; desc_wlc = 8'h00; desc_rlen = 8'h00; desc_ctrl = 8'h00;
    end else desc_valid = 1'b0;
    seen_wb = 0; fin = 0; cyc = 0;
    st_tag = (ex_st == 1) ? "R10" : ((ex_st == 8) ? "R6" : "R8");
    while (!fin && cyc < 3000) begin
      if (op_done) op_done = 1'b0;
      else if (op_valid) begin
        if (e_kind.size() == 0) chk(0, tag, "unexpected op", int'(op_kind), -1);
        else begin
          k = e_kind.pop_front(); v = e_val.pop_front();
          n = e_nak.pop_front(); r = e_rd.pop_front();
          chk(int'(op_kind) == k, tag, "op kind", op_kind, k);
          if (k == 1) chk(int'(op_data) == v, tag, "write byte", op_data, v);
          if (k == 2) chk(int'(op_ack) == v, (tag == "R8") ? "R7" : "R5", "read ack", op_ack, v);
          op_nak = n[0]; op_rdata = 8'(r); op_done = 1'b1;
        end
      end
      if (seen_wb) begin
        chk(done == 1'b1, "R11", "done after write-back", done, 1);
        chk(irq == c[6], "R11", "irq", irq, c[6]);
        fin = 1;
      end else if (wb_valid) begin
        seen_wb = 1;
        chk(int'(wb_status) == ex_st, st_tag, "status", wb_status, ex_st);
        chk(int'(wb_tx_cnt) == ex_tx, "R3", "tx count", wb_tx_cnt, ex_tx);
        chk(int'(wb_rx_cnt) == ex_rx, "R5", "rx count", wb_rx_cnt, ex_rx);
        desc_valid = 1'b0;
      end
      if (!fin) begin @(negedge clk); cyc++; end
    end
    if (!fin) chk(0, tag, "transaction timeout", cyc, 0);
    chk(e_kind.size() == 0, tag, "ops missing", e_kind.size(), 0);
    for (int i = 0; i < ex_rx; i++) chk(int'(mem[i]) == ex_buf[i], "R5", "stored byte", mem[i], ex_buf[i]);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    rst = 1'b1; desc_valid = 1'b0; desc_addr = '0; desc_rw = 1'b0;
    desc_wlc = '0; desc_rlen = '0; desc_ctrl = '0;
    op_done = 1'b0; op_nak = 1'b0; op_rdata = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(desc_ready == 1'b1, "R13", "reset ready", desc_ready, 1);
    chk(op_valid == 1'b0, "R13", "reset op_valid", op_valid, 0);
    chk(wb_valid == 1'b0, "R13", "reset wb_valid", wb_valid, 0);
    chk(done == 1'b0 && irq == 1'b0, "R13", "reset done/irq", {done, irq}, 0);
    rst = 1'b0;
    @(negedge clk);

    wd = '{}; sb = '{};
    run_case("R2", 7'h2A, 0, 0, 0, 8'h00, -1, 0);          // quick write
    run_case("R1", 7'h11, 1, 0, 0, 8'h00, -1, 0);          // quick read
    run_case("R3", 7'h50, 0, 8'hA5, 0, 8'h01, -1, 0);      // literal command byte
    wd = '{8'h10, 8'h34, 8'h12};
    run_case("R3", 7'h33, 0, 3, 0, 8'h40, -1, 0);          // buffer write, irq enabled
    wd = '{}; sb = '{8'hCD, 8'hAB};
    run_case("R4", 7'h48, 1, 8'h07, 2, 8'h01, -1, 0);      // read word
    wd = '{8'h09, 8'h78, 8'h56}; sb = '{8'h11, 8'h22};
    run_case("R4", 7'h21, 0, 3, 2, 8'h00, -1, 0);          // process call
    wd = '{}; sb = '{8'h5A};
    run_case("R5", 7'h0C, 1, 0, 1, 8'h00, -1, 0);          // receive byte
    run_case("R6", 7'h3C, 0, 8'h44, 2, 8'h01, 0, 0);       // address NAK
    wd = '{8'hE1, 8'hE2, 8'hE3};
    run_case("R6", 7'h3D, 0, 3, 0, 8'h00, 2, 0);           // NAK on second data byte
    wd = '{}; sb = '{8'h01, 8'h02};
    run_case("R6", 7'h3E, 0, 8'h10, 2, 8'h01, 2, 0);       // NAK on repeated-start address
    wd = '{8'h30, 8'hA1, 8'hA2, 8'hA3};
    run_case("R7", 7'h2B, 0, 4, 0, 8'h04, -1, 0);          // block write, count inserted
    run_case("R9", 7'h2B, 0, 4, 0, 8'h24, -1, 0);          // I2C block write, no count
    wd = '{}; sb = '{3, 8'hB1, 8'hB2, 8'hB3};
    run_case("R7", 7'h19, 0, 8'h40, 32, 8'h05, -1, 0);     // block read
    sb = '{33};
    run_case("R8", 7'h19, 0, 8'h40, 40, 8'h05, -1, 0);     // count above limit
    sb = '{5};
    run_case("R8", 7'h19, 0, 8'h40, 4, 8'h05, -1, 0);      // count above read length
    sb = '{0};
    run_case("R8", 7'h19, 0, 8'h40, 4, 8'h05, -1, 0);      // zero count
    sb = '{8'h99, 8'h98, 8'h97, 8'h96};
    run_case("R9", 7'h1A, 0, 8'h50, 4, 8'h25, -1, 0);      // I2C block read
    sb = '{8'h61, 8'h62};
    run_case("R12", 7'h48, 1, 8'h08, 2, 8'h41, -1, 1);     // conflicting descriptor held

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule